// File: doc/BRIEF.md
# Aligned Line Copy Engine

This block copies a contiguous region of memory to another place, one whole 64-byte line at a time. Software writes a source address, a destination address and a byte count into a small bank of 32-bit registers, then writes the start bit. The engine checks the request before it accepts it. If the request passes, it fetches lines in ascending order through a read master and sends them out in the same order through a write master. A small line buffer sits between the two masters.

Addresses are 50 bits wide, so one request can cover both the device half and the host half of the map. When neither side stalls, the engine moves one line per clock. When the last line has been handed to the write side, the engine sets a completion flag. That flag drives the interrupt line, provided the interrupt is enabled. A request that breaks a rule sets an error flag and moves nothing.

Register map: each register is one 32-bit word, selected by a 3-bit word index.

| Index | Contents |
|-------|----------|
| 0 | Source address bits 31:0 |
| 1 | Source address bits 49:32, held in bits 17:0 |
| 2 | Destination address bits 31:0 |
| 3 | Destination address bits 49:32, held in bits 17:0 |
| 4 | Byte count, 32 bits |
| 5 | Control: bit 0 is start (write 1; always reads 0), bit 1 is interrupt enable |
| 6 | Status: bit 0 is busy (read-only), bit 1 is done (write 1 to clear), bit 2 is error (write 1 to clear) |

Top module: `line_copy_engine`

## Requirements
- R1: A register write takes effect only when all four byte enables are set. A write with any other byte-enable pattern leaves every register unchanged. Read data appears on `csr_rdata` one cycle after `csr_rd` is high.
- R2: A start request is rejected if bits 5:0 of the source address or of the destination address are not zero. A rejected request sets status bit 2, leaves busy low and issues no read and no write.
- R3: A start request is also rejected if the byte count is zero, is not a multiple of 64, or exceeds 16,777,152. Rejection behaves exactly as in R2.
- R4: An accepted request with byte count 64·N issues exactly N reads, at source + 64·k for k = 0 to N−1. It issues exactly N writes, at destination + 64·k. Write k carries the data returned by read k.
- R5: The high address registers hold 18 bits. Writing all ones to one of them reads back 0x3FFFF, and transfers use the full 50-bit address.
- R6: With no stalls, and with read data returned two cycles after each request, the interrupt rises no more than N+6 cycles after the cycle that accepts the start write.
- R7: The line buffer never overflows or underflows, whatever the read and write stall patterns. Read issue is held back so that outstanding reads plus buffered lines never exceed the buffer depth.
- R8: Busy stays high from acceptance until the last write is accepted. In that cycle busy falls and done sets. Writing 1 to status bit 1 clears done.
- R9: A start write while busy is ignored. The running transfer carries on with its latched addresses and count.
- R10: The interrupt output is high exactly while done and the interrupt enable (control bit 1) are both set. An error does not raise it.
- R11: An accepted start clears any done or error flag left over from an earlier request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 3 | Register word index |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_be | input | 4 | Byte enables; a write counts only when all four are set |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one cycle after `csr_rd` |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | 50 | Read line address |
| rd_ready | input | 1 | Read request accepted when high with `rd_req` |
| rd_rvalid | input | 1 | Read data valid; responses arrive in request order |
| rd_rdata | input | 512 | Read line data |
| wr_valid | output | 1 | Write valid |
| wr_addr | output | 50 | Write line address |
| wr_data | output | 512 | Write line data |
| wr_ready | input | 1 | Write accepted when high with `wr_valid` |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps transfer lengths of one to six lines against four stall patterns. It also places source and destination in opposite halves of the 50-bit map. A design that dropped or repeated a line, reordered data, or let the buffer overrun under a slow write side would show a line count or data mismatch. Each rejection cause is tried on its own. A check that a wrong design let through would show up as a stray read or write, and a wrong status flag would show up on read-back. The bench also covers a start while busy, a byte-masked write, stale flags and a masked interrupt. A design that restarted mid-copy, latched partial writes, or kept old flags would show a wrong count, register value or interrupt level.

// File: rtl/lce_pkg.sv
package lce_pkg;
  localparam int unsigned ADDR_W     = 50;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned LINE_W     = LINE_BYTES * 8;
  localparam int unsigned OFS_W      = $clog2(LINE_BYTES);
  localparam int unsigned LEN_W      = 32;
  localparam int unsigned HI_W       = ADDR_W - 32;
  localparam longint unsigned MAX_BYTES = 64'd16777152;
  localparam int unsigned MAX_LINES  = int'(MAX_BYTES / LINE_BYTES);
  localparam int unsigned CNT_W      = $clog2(MAX_LINES + 1);

  // register word indices
  localparam logic [2:0] RG_SRC_LO = 3'd0;
  localparam logic [2:0] RG_SRC_HI = 3'd1;
  localparam logic [2:0] RG_DST_LO = 3'd2;
  localparam logic [2:0] RG_DST_HI = 3'd3;
  localparam logic [2:0] RG_LEN    = 3'd4;
  localparam logic [2:0] RG_CTRL   = 3'd5;
  localparam logic [2:0] RG_STAT   = 3'd6;

  // bit positions
  localparam int unsigned CTRL_GO  = 0;
  localparam int unsigned CTRL_IEN = 1;
  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_DONE  = 1;
  localparam int unsigned ST_ERR   = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [LEN_W-1:0]  len;
  } desc_t;

  function automatic logic line_aligned(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0] == '0;
  endfunction

  function automatic logic len_legal(input logic [LEN_W-1:0] n);
    return (n != '0) && (n[OFS_W-1:0] == '0) && (64'(n) <= MAX_BYTES);
  endfunction

  function automatic logic desc_ok(input desc_t d);
    return line_aligned(d.src) && line_aligned(d.dst) && len_legal(d.len);
  endfunction

  function automatic logic [CNT_W-1:0] line_count(input logic [LEN_W-1:0] n);
    return CNT_W'(n >> OFS_W);
  endfunction

  function automatic logic [ADDR_W-1:0] next_line(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(LINE_BYTES);
  endfunction
endpackage

// File: rtl/lce_fifo.sv
module lce_fifo #(
  parameter int unsigned W     = 512,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [OCC_W-1:0] occ;
  logic             full;

  assign empty = (occ == '0);
  assign full  = (occ == OCC_W'(DEPTH));
  assign dout  = slot[rptr];

  always_ff @(posedge clk) begin
    if (push) slot[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push) wptr <= wptr + PTR_W'(1);
      if (pop)  rptr <= rptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: ;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/lce_csr.sv
module lce_csr
  import lce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  csr_addr,
  input  logic        csr_wr,
  input  logic        csr_rd,
  input  logic [3:0]  csr_be,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        busy,
  input  logic        last_evt,
  output desc_t       desc,
  output logic        start,
  output logic        irq
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              ien_q, done_q, err_q;
  logic              wr_ok, go_wr, go_ok, go_bad, stat_wr, desc_good;
  logic [31:0]       rd_mux;

  always_comb begin
    desc.src = src_q;
    desc.dst = dst_q;
    desc.len = len_q;
  end

  assign desc_good = desc_ok(desc);
  assign wr_ok     = csr_wr && (csr_be == 4'hF);
  assign go_wr     = wr_ok && (csr_addr == RG_CTRL) && csr_wdata[CTRL_GO];
  assign go_ok     = go_wr && !busy && desc_good;
  assign go_bad    = go_wr && !busy && !desc_good;
  assign stat_wr   = wr_ok && (csr_addr == RG_STAT);
  assign start     = go_ok;
  assign irq       = ien_q && done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      ien_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (csr_addr)
          RG_SRC_LO: src_q[31:0]       <= csr_wdata;
          RG_SRC_HI: src_q[ADDR_W-1:32] <= csr_wdata[HI_W-1:0];
          RG_DST_LO: dst_q[31:0]       <= csr_wdata;
          RG_DST_HI: dst_q[ADDR_W-1:32] <= csr_wdata[HI_W-1:0];
          RG_LEN:    len_q             <= csr_wdata;
          RG_CTRL:   ien_q             <= csr_wdata[CTRL_IEN];
          default: ;
        endcase
      end
      if (last_evt)                          done_q <= 1'b1;
      else if (go_ok)                        done_q <= 1'b0;
      else if (stat_wr && csr_wdata[ST_DONE]) done_q <= 1'b0;
      if (go_bad)                            err_q <= 1'b1;
      else if (go_ok)                        err_q <= 1'b0;
      else if (stat_wr && csr_wdata[ST_ERR])  err_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (csr_addr)
      RG_SRC_LO: rd_mux = src_q[31:0];
      RG_SRC_HI: rd_mux = 32'(src_q[ADDR_W-1:32]);
      RG_DST_LO: rd_mux = dst_q[31:0];
      RG_DST_HI: rd_mux = 32'(dst_q[ADDR_W-1:32]);
      RG_LEN:    rd_mux = len_q;
      RG_CTRL:   rd_mux[CTRL_IEN] = ien_q;
      RG_STAT: begin
        rd_mux[ST_BUSY] = busy;
        rd_mux[ST_DONE] = done_q;
        rd_mux[ST_ERR]  = err_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr_rdata <= '0;
    else        csr_rdata <= csr_rd ? rd_mux : '0;
  end

  // R2 R3
  rejected_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_bad |=> (!busy && err_q));
  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(last_evt));
  // R9
  busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && busy) |=> $stable(err_q));
endmodule

// File: rtl/lce_seq.sv
module lce_seq
  import lce_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  desc_t             desc,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rd_rvalid,
  input  logic              fifo_empty,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_ready,
  output logic              push,
  output logic              pop,
  output logic              busy,
  output logic              last_evt
);
  localparam int unsigned RES_W = $clog2(DEPTH + 1);

  logic              busy_q;
  logic [ADDR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  rd_left, wr_left;
  logic [RES_W-1:0]  reserved;
  logic              rd_fire, wr_fire;

  // reads are issued only while a buffer slot is still unclaimed
  assign rd_req   = busy_q && (rd_left != '0) && (reserved < RES_W'(DEPTH));
  assign rd_fire  = rd_req && rd_ready;
  assign wr_valid = busy_q && !fifo_empty;
  assign wr_fire  = wr_valid && wr_ready;
  assign push     = busy_q && rd_rvalid;
  assign pop      = wr_fire;
  assign last_evt = wr_fire && (wr_left == CNT_W'(1));
  assign rd_addr  = rd_ptr;
  assign wr_addr  = wr_ptr;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      rd_left  <= '0;
      wr_left  <= '0;
      reserved <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      rd_ptr   <= desc.src;
      wr_ptr   <= desc.dst;
      rd_left  <= line_count(desc.len);
      wr_left  <= line_count(desc.len);
      reserved <= '0;
    end else begin
      if (rd_fire) begin
        rd_ptr  <= next_line(rd_ptr);
        rd_left <= rd_left - CNT_W'(1);
      end
      if (wr_fire) begin
        wr_ptr  <= next_line(wr_ptr);
        wr_left <= wr_left - CNT_W'(1);
      end
      if (last_evt) busy_q <= 1'b0;
      case ({rd_fire, wr_fire})
        2'b10:   reserved <= reserved + RES_W'(1);
        2'b01:   reserved <= reserved - RES_W'(1);
        default: ;
      endcase
    end
  end

  // R7
  reserve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reserved <= RES_W'(DEPTH));
  // R4
  rd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[OFS_W-1:0] == '0));
  // R4
  wr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[OFS_W-1:0] == '0));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_evt) |=> busy_q);
  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/line_copy_engine.sv
module line_copy_engine
  import lce_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        csr_addr,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [3:0]        csr_be,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rd_rvalid,
  input  logic [LINE_W-1:0] rd_rdata,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LINE_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic              irq
);
  desc_t desc;
  logic  start, busy, last_evt, push, pop, fifo_empty;

  lce_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_addr  (csr_addr),
    .csr_wr    (csr_wr),
    .csr_rd    (csr_rd),
    .csr_be    (csr_be),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .busy      (busy),
    .last_evt  (last_evt),
    .desc      (desc),
    .start     (start),
    .irq       (irq)
  );

  lce_seq #(.DEPTH(FIFO_DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .desc       (desc),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ready   (rd_ready),
    .rd_rvalid  (rd_rvalid),
    .fifo_empty (fifo_empty),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_ready   (wr_ready),
    .push       (push),
    .pop        (pop),
    .busy       (busy),
    .last_evt   (last_evt)
  );

  lce_fifo #(.W(LINE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (rd_rdata),
    .pop   (pop),
    .dout  (wr_data),
    .empty (fifo_empty)
  );
endmodule

// File: tb/sim_line_copy_engine.sv
module sim_line_copy_engine;
  localparam int AW = 50;
  localparam int LW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    csr_addr = '0;
  logic          csr_wr = 1'b0, csr_rd = 1'b0;
  logic [3:0]    csr_be = '0;
  logic [31:0]   csr_wdata = '0, csr_rdata;
  logic          rd_req, rd_ready = 1'b0, rd_rvalid = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [LW-1:0] rd_rdata = '0, wr_data;
  logic          wr_valid, wr_ready = 1'b0, irq;

  always #4 clk = ~clk;

  line_copy_engine u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_be(csr_be), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_rvalid(rd_rvalid),
    .rd_rdata(rd_rdata), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int rd_idx = 0, wr_idx = 0, mism = 0, ncyc = 0;
  bit rd_stall = 0, wr_stall = 0;
  logic [AW-1:0] cur_src = '0, cur_dst = '0;
  logic [AW-1:0] rq[$];

  function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
    logic [LW-1:0] r;
    for (int i = 0; i < 16; i++)
      r[i*32 +: 32] = a[31:0] ^ (32'(i) * 32'h9E3779B9) ^ 32'(a[AW-1:32]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory models: drive at the falling edge, log handshakes that the next rising edge takes
  always @(negedge clk) begin
    ncyc++;
    if (!rst_n) begin
      rd_ready = 1'b0; wr_ready = 1'b0; rd_rvalid = 1'b0;
      rq.delete();
    end else begin
      if (rq.size() > 0 && (!rd_stall || (ncyc % 2 == 0))) begin
        rd_rvalid = 1'b1;
        rd_rdata  = pat(rq.pop_front());
      end else begin
        rd_rvalid = 1'b0;
      end
      rd_ready = !rd_stall || (ncyc % 3 != 1);
      wr_ready = !wr_stall || (ncyc % 4 == 0);
      #1;
      if (rd_req && rd_ready) begin
        if (rd_addr != cur_src + AW'(rd_idx) * AW'(64)) mism++;
        rq.push_back(rd_addr);
        rd_idx++;
      end
      if (wr_valid && wr_ready) begin
        if (wr_addr != cur_dst + AW'(wr_idx) * AW'(64)) mism++;
        if (wr_data != pat(cur_src + AW'(wr_idx) * AW'(64))) mism++;
        wr_idx++;
      end
    end
  end

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_be = be; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; csr_be = '0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_rd = 1'b1;
    @(negedge clk);
    csr_rd = 1'b0;
    d = csr_rdata;
  endtask

  task automatic program_desc(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [31:0] n);
    csr_write(3'd0, s[31:0], 4'hF);
    csr_write(3'd1, 32'(s[AW-1:32]), 4'hF);
    csr_write(3'd2, d[31:0], 4'hF);
    csr_write(3'd3, 32'(d[AW-1:32]), 4'hF);
    csr_write(3'd4, n, 4'hF);
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    int k = 0;
    do begin
      csr_read(3'd6, st);
      k++;
    end while (st[0] && k < 4000);
  endtask

  task automatic run_copy(input logic [AW-1:0] s, input logic [AW-1:0] d, input int lines,
                          input logic [31:0] ctrl, output int cyc);
    cur_src = s; cur_dst = d; rd_idx = 0; wr_idx = 0; mism = 0;
    program_desc(s, d, 32'(lines * 64));
    csr_write(3'd5, ctrl, 4'hF);
    cyc = 0;
    if (ctrl[1]) while (!irq && cyc < 4000) begin @(negedge clk); cyc++; end
    wait_idle();
  endtask

  task automatic expect_reject(input logic [AW-1:0] s, input logic [AW-1:0] d,
                               input logic [31:0] n, input string req);
    logic [31:0] st;
    csr_write(3'd6, 32'h6, 4'hF);
    cur_src = s; cur_dst = d; rd_idx = 0; wr_idx = 0; mism = 0;
    program_desc(s, d, n);
    csr_write(3'd5, 32'h3, 4'hF);
    csr_read(3'd6, st);
    check(st == 32'h4, {req, " error status"}, longint'(st), 4);
    repeat (6) @(negedge clk);
    check(rd_idx == 0 && wr_idx == 0, {req, " no traffic"}, rd_idx + wr_idx, 0);
    check(irq == 1'b0, {req, " R10 no irq on error"}, longint'(irq), 0);
    csr_write(3'd6, 32'h4, 4'hF);
    csr_read(3'd6, st);
    check(st == 32'h0, {req, " error cleared"}, longint'(st), 0);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] st;
    int cyc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state: R8 R10
    csr_read(3'd6, st);
    check(st == 32'h0, "R8 reset status", longint'(st), 0);
    check(irq == 1'b0 && rd_req == 1'b0 && wr_valid == 1'b0, "R10 reset outputs idle",
          longint'({irq, rd_req, wr_valid}), 0);
    csr_read(3'd4, st);
    check(st == 32'h0, "R1 reset length", longint'(st), 0);

    // R1 register read-back and masked write
    csr_write(3'd0, 32'hDEADBE40, 4'hF);
    csr_read(3'd0, st);
    check(st == 32'hDEADBE40, "R1 source low read-back", longint'(st), 32'hDEADBE40);
    csr_write(3'd4, 32'h40, 4'hF);
    csr_write(3'd4, 32'h80, 4'h3);
    csr_read(3'd4, st);
    check(st == 32'h40, "R1 partial byte write ignored", longint'(st), 32'h40);
    csr_write(3'd5, 32'h3, 4'h1);
    csr_read(3'd6, st);
    check(st == 32'h0, "R1 masked start ignored", longint'(st), 0);

    // R5 high address register width
    csr_write(3'd1, 32'hFFFFFFFF, 4'hF);
    csr_read(3'd1, st);
    check(st == 32'h3FFFF, "R5 high register width", longint'(st), 32'h3FFFF);

    // R4 R5 R6 R7 sweep over lengths and stall patterns
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 6; n++) begin
        logic [AW-1:0] s, d;
        rd_stall = m[0]; wr_stall = m[1];
        s = (m[0] ? 50'h2_0000_0000_0000 : 50'h0) + AW'(n * 4096) + AW'(m * 65536);
        d = (m[0] ? 50'h0 : 50'h3_FFFF_0000_0000) + AW'(n * 8192) + 50'h40;
        run_copy(s, d, n, 32'h3, cyc);
        check(rd_idx == n, "R4 read count", rd_idx, n);
        check(wr_idx == n, "R4 R7 write count", wr_idx, n);
        check(mism == 0, "R4 R5 R7 addresses and data", mism, 0);
        csr_read(3'd6, st);
        check(st == 32'h2, "R8 done after copy", longint'(st), 2);
        if (m == 0) check(cyc <= n + 6, "R6 no-stall latency", cyc, n + 6);
      end
    end
    rd_stall = 0; wr_stall = 0;

    // R8 R10 done write-one-to-clear drops irq
    check(irq == 1'b1, "R10 irq while done", longint'(irq), 1);
    csr_write(3'd6, 32'h2, 4'hF);
    csr_read(3'd6, st);
    check(st == 32'h0, "R8 done cleared", longint'(st), 0);
    check(irq == 1'b0, "R10 irq cleared", longint'(irq), 0);

    // R2 R3 rejections
    expect_reject(50'h1010, 50'h2000, 32'h80, "R2 source misaligned");
    expect_reject(50'h1000, 50'h2001, 32'h80, "R2 destination misaligned");
    expect_reject(50'h1000, 50'h2000, 32'd100, "R3 length not line multiple");
    expect_reject(50'h1000, 50'h2000, 32'd0, "R3 zero length");
    expect_reject(50'h1000, 50'h2000, 32'd16777216, "R3 length over maximum");

    // R11 stale error cleared by an accepted start
    program_desc(50'h40, 50'h80, 32'd10);
    csr_write(3'd5, 32'h1, 4'hF);
    run_copy(50'h4000, 50'h8000, 2, 32'h1, cyc);
    csr_read(3'd6, st);
    check(st == 32'h2, "R11 stale error cleared", longint'(st), 2);
    check(mism == 0 && wr_idx == 2, "R11 copy after error", wr_idx, 2);

    // R10 masked interrupt
    check(irq == 1'b0, "R10 irq masked", longint'(irq), 0);
    csr_write(3'd5, 32'h2, 4'hF);
    @(negedge clk);
    check(irq == 1'b1, "R10 irq unmasked while done", longint'(irq), 1);

    // R9 start while busy ignored
    wr_stall = 1;
    cur_src = 50'h1_0000_0000_0000; cur_dst = 50'h5000; rd_idx = 0; wr_idx = 0; mism = 0;
    program_desc(cur_src, cur_dst, 32'd384);
    csr_write(3'd5, 32'h3, 4'hF);
    csr_write(3'd0, 32'h00777000, 4'hF);
    csr_write(3'd5, 32'h3, 4'hF);
    csr_read(3'd6, st);
    check(st == 32'h1, "R9 busy after second start", longint'(st), 1);
    wait_idle();
    check(wr_idx == 6 && rd_idx == 6, "R9 original count kept", wr_idx, 6);
    check(mism == 0, "R9 original addresses kept", mism, 0);
    wr_stall = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule